// File: doc/BRIEF.md
# Receive Descriptor Status Writer

This block closes receive buffer descriptors in an Ethernet descriptor ring. The MAC receive path signals one close event per buffer. Each event says either that an intermediate buffer has filled or that a frame has ended. A frame-end event carries the destination address, the byte count including CRC, the CRC and alignment results, the overrun flag and the address-filter verdict. From these inputs and the preserved bits of the current descriptor, the block builds a 16-bit status word and a 16-bit length word.

The block posts one write request for the descriptor at the current ring pointer and holds it until the memory side accepts it. When the write is accepted, the pointer either steps to the next descriptor slot or returns to the ring start, depending on the Wrap bit. Only one close can be outstanding at a time. While a write waits, the event side is stalled by the `ev_ready` signal.

Top module: `rx_desc_closer`

## Requirements
- R1: Every status word written has bit 15 (Empty) at 0. Bits 14, 13 (Wrap) and 12 are copied from `desc_cur_bits[2:0]`, in that order. Bits 10, 9 and 3 are 0.
- R2: Bit 11 (Last) is 1 exactly for a frame-end event. On an intermediate close, status bits 8..0 are all 0 and the length word equals `cfg_buf_size`.
- R3: On a frame-end close, the length word equals `ev_len`, which is the frame byte count including CRC.
- R4: Bit 7 is 1 when all 48 destination bits are 1. Bit 6 is 1 when `ev_dest[40]` (the low bit of the first address byte, which sits in `ev_dest[47:40]`) is 1 and the address is not broadcast.
- R5: Bit 8 is 1 when `cfg_promisc` is 1 and `ev_addr_hit` is 0.
- R6: Bit 5 is 1 when `ev_len > cfg_max_len`. Bit 0 is 1 when `ev_len > 2047`. A length equal to either limit sets nothing.
- R7: Bit 4 is 1 when both `ev_odd_bits` and `ev_crc_bad` are 1. Bit 2 is 1 when `ev_crc_bad` is 1 and `ev_odd_bits` is 0. The two are never both set, and `ev_odd_bits` alone sets neither.
- R8: Bit 1 reflects `ev_overrun`. When it is 1, bits 8, 5, 4 and 2 are 0, while bits 7, 6 and 0 keep their normal meaning.
- R9: When a write completes (`wr_valid` and `wr_ready` both 1), `desc_ptr` becomes `cfg_ring_base` if the written Wrap bit is 1. Otherwise it becomes the old pointer plus 8.
- R10: A posted request keeps `wr_addr`, `wr_status` and `wr_length` stable until `wr_ready`. `wr_addr` equals `desc_ptr`. `ev_ready` is 0 while a request is pending, and the pointer does not move before completion.
- R11: After reset `wr_valid` and `ev_ready` are 0. On the first clock, `desc_ptr` loads `cfg_ring_base`, and only then is an event accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_base | input | ADDR_W | Byte address of the first descriptor in the ring |
| cfg_buf_size | input | LEN_W | Receive buffer size reported for intermediate buffers |
| cfg_max_len | input | LEN_W | Maximum frame length before the long flag is raised |
| cfg_promisc | input | 1 | Promiscuous reception enabled |
| desc_cur_bits | input | 3 | Current descriptor status bits 14..12 |
| ev_valid | input | 1 | Close event present |
| ev_ready | output | 1 | Close event accepted this cycle when valid |
| ev_last | input | 1 | Event ends a frame (1) or closes a full intermediate buffer (0) |
| ev_dest | input | 48 | Destination address, first byte in bits 47:40 |
| ev_len | input | LEN_W | Frame length in bytes including CRC |
| ev_odd_bits | input | 1 | Frame bit count not a multiple of 8 |
| ev_crc_bad | input | 1 | CRC check failed |
| ev_overrun | input | 1 | Receive FIFO overran during the frame |
| ev_addr_hit | input | 1 | Address filter matched |
| wr_valid | output | 1 | Descriptor write request pending |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | ADDR_W | Descriptor byte address |
| wr_status | output | 16 | Status word to write |
| wr_length | output | LEN_W | Length word to write |
| desc_ptr | output | ADDR_W | Current descriptor pointer |

## Verification
Two things can land in the same cycle. The first is the completion of a pending descriptor write, which moves the pointer, possibly back to the ring start. The second is the arrival of the next close event, which must not be captured against the old pointer. The bench drives `wr_ready` with an irregular pattern and queues events back to back, so completions repeatedly coincide with a waiting event. Some of these completions carry the Wrap bit. A behavioural model predicts, every cycle, the pointer, the handshake signals and each status field group. The bench judges the design against that model, so an event slipping in early or landing on a stale address is caught in the cycle it happens.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // status word bit positions (fixed by the descriptor format)
  localparam int ST_EMPTY = 15;
  localparam int ST_SWA   = 14;
  localparam int ST_WRAP  = 13;
  localparam int ST_SWB   = 12;
  localparam int ST_LAST  = 11;
  localparam int ST_MISS  = 8;
  localparam int ST_BCAST = 7;
  localparam int ST_MCAST = 6;
  localparam int ST_LONG  = 5;
  localparam int ST_ODD   = 4;
  localparam int ST_CRC   = 2;
  localparam int ST_OVR   = 1;
  localparam int ST_TRUNC = 0;
  localparam int STAT_W   = 16;
  localparam int MAC_W    = 48;
  localparam int GROUP_BIT = 40;

  typedef struct packed {
    logic             last;
    logic [MAC_W-1:0] dest;
    logic             odd;
    logic             crc;
    logic             ovr;
    logic             hit;
  } frm_evt_t;
endpackage

// File: rtl/rxd_status_build.sv
module rxd_status_build
  import rxd_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int TRUNC_LIMIT = 2047
) (
  input  frm_evt_t            evt,
  input  logic [LEN_W-1:0]    len,
  input  logic [LEN_W-1:0]    buf_size,
  input  logic [LEN_W-1:0]    max_len,
  input  logic                promisc,
  input  logic [2:0]          keep_bits,
  output logic [STAT_W-1:0]   status,
  output logic [LEN_W-1:0]    length
);
  localparam logic [LEN_W-1:0] TRUNC_L = LEN_W'(TRUNC_LIMIT);

  logic bcast, mcast, miss, too_long, trunc, odd_err, crc_err;

  always_comb begin
    bcast    = &evt.dest;
    mcast    = evt.dest[GROUP_BIT] & ~bcast;
    trunc    = len > TRUNC_L;
    miss     = promisc & ~evt.hit & ~evt.ovr;
    too_long = (len > max_len) & ~evt.ovr;
    odd_err  = evt.odd & evt.crc & ~evt.ovr;
    crc_err  = ~evt.odd & evt.crc & ~evt.ovr;
  end

  always_comb begin
    status          = '0;
    status[ST_SWA]  = keep_bits[2];
    status[ST_WRAP] = keep_bits[1];
    status[ST_SWB]  = keep_bits[0];
    length          = buf_size;
    if (evt.last) begin
      status[ST_LAST]  = 1'b1;
      status[ST_BCAST] = bcast;
      status[ST_MCAST] = mcast;
      status[ST_TRUNC] = trunc;
      status[ST_OVR]   = evt.ovr;
      status[ST_MISS]  = miss;
      status[ST_LONG]  = too_long;
      status[ST_ODD]   = odd_err;
      status[ST_CRC]   = crc_err;
      length           = len;
    end
  end
endmodule

// File: rtl/rxd_ptr_unit.sv
module rxd_ptr_unit #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] ptr,
  output logic              ptr_ok
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] ptr_nx;
  logic              ptr_en;

  always_comb begin
    ptr_en = ~ptr_ok | advance;
    if (!ptr_ok || wrap) ptr_nx = base;
    else                 ptr_nx = ptr + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      ptr_ok <= 1'b0;
    end else begin
      ptr_ok <= 1'b1;
      if (ptr_en) ptr <= ptr_nx;
    end
  end
endmodule

// File: rtl/rxd_wr_port.sv
module rxd_wr_port #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [STAT_W-1:0] in_status,
  input  logic [LEN_W-1:0]  in_length,
  input  logic              ready,
  output logic              valid,
  output logic              done,
  output logic [ADDR_W-1:0] addr,
  output logic [STAT_W-1:0] status,
  output logic [LEN_W-1:0]  length
);
  logic valid_nx;

  always_comb begin
    done     = valid & ready;
    valid_nx = valid;
    if (capture)   valid_nx = 1'b1;
    else if (done) valid_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      status <= '0;
      length <= '0;
    end else if (capture) begin
      addr   <= in_addr;
      status <= in_status;
      length <= in_length;
    end
  end
endmodule

// File: rtl/rx_desc_closer.sv
module rx_desc_closer
  import rxd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DESC_BYTES  = 8,
  parameter int TRUNC_LIMIT = 2047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [LEN_W-1:0]  cfg_buf_size,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_promisc,
  input  logic [2:0]        desc_cur_bits,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_last,
  input  logic [47:0]       ev_dest,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_odd_bits,
  input  logic              ev_crc_bad,
  input  logic              ev_overrun,
  input  logic              ev_addr_hit,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_status,
  output logic [LEN_W-1:0]  wr_length,
  output logic [ADDR_W-1:0] desc_ptr
);
  frm_evt_t          evt;
  logic [STAT_W-1:0] st_new;
  logic [LEN_W-1:0]  len_new;
  logic              ptr_ok, capture, wr_done;

  always_comb begin
    evt.last = ev_last;
    evt.dest = ev_dest;
    evt.odd  = ev_odd_bits;
    evt.crc  = ev_crc_bad;
    evt.ovr  = ev_overrun;
    evt.hit  = ev_addr_hit;
    ev_ready = ptr_ok & ~wr_valid;
    capture  = ev_valid & ev_ready;
  end

  rxd_status_build #(.LEN_W(LEN_W), .TRUNC_LIMIT(TRUNC_LIMIT)) build_i (
    .evt(evt), .len(ev_len), .buf_size(cfg_buf_size), .max_len(cfg_max_len),
    .promisc(cfg_promisc), .keep_bits(desc_cur_bits),
    .status(st_new), .length(len_new)
  );

  rxd_wr_port #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAT_W(STAT_W)) port_i (
    .clk(clk), .rst_n(rst_n), .capture(capture), .in_addr(desc_ptr),
    .in_status(st_new), .in_length(len_new), .ready(wr_ready),
    .valid(wr_valid), .done(wr_done), .addr(wr_addr),
    .status(wr_status), .length(wr_length)
  );

  rxd_ptr_unit #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) ptr_i (
    .clk(clk), .rst_n(rst_n), .base(cfg_ring_base), .advance(wr_done),
    .wrap(wr_status[ST_WRAP]), .ptr(desc_ptr), .ptr_ok(ptr_ok)
  );
endmodule

// File: rtl/rx_desc_closer_chk.sv
module rx_desc_closer_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DESC_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_ring_base,
  input logic [LEN_W-1:0]  cfg_buf_size,
  input logic [2:0]        desc_cur_bits,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              ev_last,
  input logic [LEN_W-1:0]  ev_len,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_status,
  input logic [LEN_W-1:0]  wr_length,
  input logic [ADDR_W-1:0] desc_ptr
);
  // R1
  close_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> wr_valid && !wr_status[15] &&
      wr_status[14:12] == $past(desc_cur_bits) && wr_status[10:9] == 2'b00 && !wr_status[3]);
  // R2
  mid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_status[11] |-> wr_status[8:0] == 9'd0);
  // R2
  mid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !ev_last |=> wr_length == $past(cfg_buf_size));
  // R3
  last_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_last |=> wr_length == $past(ev_len) && wr_status[11]);
  // R4
  cast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !(wr_status[7] && wr_status[6]));
  // R7
  align_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !(wr_status[4] && wr_status[2]));
  // R8
  ovr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_status[1] |-> !wr_status[8] && !wr_status[5] && !wr_status[4] && !wr_status[2]);
  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> desc_ptr == ($past(wr_status[13]) ? $past(cfg_ring_base)
                                          : $past(wr_addr) + ADDR_W'(DESC_BYTES)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_status) &&
      $stable(wr_length) && $stable(desc_ptr));
  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !ev_ready && wr_addr == desc_ptr);
endmodule

bind rx_desc_closer rx_desc_closer_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_BYTES(DESC_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_buf_size(cfg_buf_size),
  .desc_cur_bits(desc_cur_bits), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_last(ev_last), .ev_len(ev_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_status(wr_status), .wr_length(wr_length), .desc_ptr(desc_ptr)
);

// File: tb/rx_desc_closer_tb_top.sv
module rx_desc_closer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_ring_base = 32'h0000_1000;
  logic [15:0] cfg_buf_size = 16'd512;
  logic [15:0] cfg_max_len = 16'd1518;
  logic        cfg_promisc = 1'b0;
  logic [2:0]  desc_cur_bits = 3'b000;
  logic        ev_valid = 1'b0, ev_last = 1'b0, ev_odd_bits = 1'b0;
  logic        ev_crc_bad = 1'b0, ev_overrun = 1'b0, ev_addr_hit = 1'b0;
  logic [47:0] ev_dest = '0;
  logic [15:0] ev_len = '0;
  logic        wr_ready = 1'b0;
  logic        ev_ready, wr_valid;
  logic [31:0] wr_addr, desc_ptr;
  logic [15:0] wr_status, wr_length;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_desc_closer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_buf_size(cfg_buf_size),
    .cfg_max_len(cfg_max_len), .cfg_promisc(cfg_promisc), .desc_cur_bits(desc_cur_bits),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_last(ev_last), .ev_dest(ev_dest),
    .ev_len(ev_len), .ev_odd_bits(ev_odd_bits), .ev_crc_bad(ev_crc_bad),
    .ev_overrun(ev_overrun), .ev_addr_hit(ev_addr_hit), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_status(wr_status),
    .wr_length(wr_length), .desc_ptr(desc_ptr)
  );

  // behavioural reference
  bit          m_ok, m_pend, m_last;
  logic [31:0] m_ptr;
  logic [15:0] m_stat, m_len;

  function automatic logic [15:0] exp_status(input bit last, input logic [47:0] da,
      input int len, input bit odd, input bit crc, input bit ov, input bit hit,
      input bit prom, input int maxl, input logic [2:0] keep);
    logic [15:0] s = '0;
    bit bc;
    s[14] = keep[2]; s[13] = keep[1]; s[12] = keep[0];
    if (last) begin
      bc = (da == 48'hFFFF_FFFF_FFFF);
      s[11] = 1'b1;
      s[7] = bc;
      s[6] = da[40] && !bc;
      s[0] = len > 2047;
      s[1] = ov;
      if (!ov) begin
        s[8] = prom && !hit;
        s[5] = len > maxl;
        if (crc) begin
          if (odd) s[4] = 1'b1;
          else     s[2] = 1'b1;
        end
      end
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ok <= 1'b0; m_pend <= 1'b0; m_ptr <= '0;
    end else if (!m_ok) begin
      m_ok <= 1'b1; m_ptr <= cfg_ring_base;
    end else if (m_pend) begin
      if (wr_ready) begin
        m_pend <= 1'b0;
        m_ptr  <= m_stat[13] ? cfg_ring_base : m_ptr + 32'd8;
      end
    end else if (ev_valid) begin
      m_pend <= 1'b1;
      m_last <= ev_last;
      m_stat <= exp_status(ev_last, ev_dest, int'(ev_len), ev_odd_bits, ev_crc_bad,
                           ev_overrun, ev_addr_hit, cfg_promisc, int'(cfg_max_len), desc_cur_bits);
      m_len  <= ev_last ? ev_len : cfg_buf_size;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic chk_field(input string req, input logic [15:0] mask);
    chk((wr_status & mask) == (m_stat & mask), req, {16'd0, wr_status & mask}, {16'd0, m_stat & mask});
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk(!wr_valid, "R11 reset wr_valid", {31'd0, wr_valid}, 32'd0);
      chk(!ev_ready, "R11 reset ev_ready", {31'd0, ev_ready}, 32'd0);
    end else begin
      chk(ev_ready == (m_ok && !m_pend), "R10 ev_ready", {31'd0, ev_ready}, {31'd0, m_ok && !m_pend});
      chk(desc_ptr == m_ptr, m_ok ? "R9 desc_ptr" : "R11 desc_ptr", desc_ptr, m_ptr);
      chk(wr_valid == m_pend, "R10 wr_valid", {31'd0, wr_valid}, {31'd0, m_pend});
      if (m_pend && wr_valid) begin
        chk(wr_addr == m_ptr, "R10 wr_addr", wr_addr, m_ptr);
        chk_field("R1 kept/zero bits", 16'hF608);
        chk_field("R2 last bit", 16'h0800);
        chk_field("R4 cast bits", 16'h00C0);
        chk_field("R5 miss bit", 16'h0100);
        chk_field("R6 long/trunc bits", 16'h0021);
        chk_field("R7 align/crc bits", 16'h0014);
        chk_field("R8 overrun bit", 16'h0002);
        chk(wr_length == m_len, m_last ? "R3 length" : "R2 length", {16'd0, wr_length}, {16'd0, m_len});
      end
    end
  end

  // irregular ready pattern
  always @(negedge clk) wr_ready <= ((cyc % 5) != 2) && ((cyc % 7) != 3) && ((cyc % 11) != 6);

  task automatic send(input bit last, input logic [47:0] da, input int len, input bit odd,
                      input bit crc, input bit ov, input bit hit, input logic [2:0] keep);
    bit ok;
    @(negedge clk);
    ev_valid = 1'b1; ev_last = last; ev_dest = da; ev_len = 16'(len);
    ev_odd_bits = odd; ev_crc_bad = crc; ev_overrun = ov; ev_addr_hit = hit;
    desc_cur_bits = keep;
    do begin
      ok = m_ok && !m_pend;
      @(negedge clk);
    end while (!ok);
    ev_valid = 1'b0;
  endtask

  localparam logic [47:0] UNI = 48'h0011_2233_4455;
  localparam logic [47:0] BCA = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCA = 48'h0100_5E00_0001;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    send(0, UNI, 0, 0, 0, 0, 1, 3'b101);       // R2 intermediate, R1 sw bits
    send(1, UNI, 64, 0, 0, 0, 1, 3'b000);      // R3 plain
    send(1, BCA, 60, 0, 0, 0, 1, 3'b010);      // R4 broadcast, R9 wrap
    send(1, MCA, 70, 0, 0, 0, 1, 3'b000);      // R4 multicast
    cfg_promisc = 1'b1;
    send(1, UNI, 1518, 0, 0, 0, 0, 3'b000);    // R5 miss, R6 equal max
    send(1, UNI, 1519, 0, 0, 0, 1, 3'b100);    // R6 long
    send(1, UNI, 2047, 0, 0, 0, 1, 3'b000);    // R6 not truncated
    send(1, UNI, 2048, 0, 0, 0, 1, 3'b000);    // R6 truncated
    send(1, UNI, 100, 1, 1, 0, 1, 3'b001);     // R7 non-octet
    send(1, UNI, 100, 0, 1, 0, 1, 3'b000);     // R7 crc
    send(1, UNI, 100, 1, 0, 0, 1, 3'b000);     // R7 odd alone
    send(1, BCA, 2100, 1, 1, 1, 0, 3'b000);    // R8 overrun masking
    @(negedge clk); cfg_ring_base = 32'h0000_2000;
    send(0, UNI, 0, 0, 0, 0, 0, 3'b111);       // R9 wrap to new base
    send(1, MCA, 64, 0, 0, 1, 1, 3'b000);      // R8 overrun keeps multicast
    cfg_promisc = 1'b0;
    send(1, UNI, 64, 0, 0, 0, 0, 3'b000);      // R5 no miss without promisc
    for (int i = 0; i < 12; i++)
      send(i % 3 == 2, MCA, 64 + i, i % 2, 1, 0, 1, (i == 7) ? 3'b010 : 3'b000); // R10 back to back
    while (m_pend) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule